// File: doc/BRIEF.md
# Multilevel Space Vector Reference Decomposer

This block brings a seven-level space vector reference down to a two-level reference in two steps, so that a plain two-level modulator can work out the dwell times. Once per sampling period the caller presents the reference as signed fixed-point alpha and beta components, together with a valid strobe and the cell voltage step E. The block first picks one of six four-level hexagons that surround the origin and moves the vector's origin to the centre of that hexagon. It then either keeps the vector, when it lies inside the inner two-level hexagon, or picks an outer two-level hexagon and moves the origin again, this time to that hexagon's centre.

A mode input selects one of two selection schemes. The full scheme uses twelve outer hexagons, with windows of 40° and 20° that alternate. The reduced scheme uses six outer hexagons with 60° windows and accepts a small coverage gap at high modulation index. Every window decision is made with half-plane sign tests against fixed-point cosine and sine constants, and the inner test compares squared magnitudes. No arctangent or square root is needed. The pipeline has a fixed depth and accepts a new input every cycle. E travels with each sample, so every result uses the E value that was sampled with its input.

Top module: `svd_ref_decomposer`

## Requirements
- R1: out_valid goes high exactly three clock cycles after in_valid is sampled high, one result for each accepted input, back to back at full rate. In any cycle with no input accepted three cycles earlier, out_valid is low and hex4_idx, hex2_idx, out_alpha and out_beta keep their values.
- R2: hex4_idx (1 to 6) gives the four-level hexagon. The windows are [-30°,30°), [30°,90°), [90°,150°), [150°,210°), [210°,270°) and [270°,330°), numbered 1 to 6 in that order. The zero vector selects 1.
- R3: The first-stage vector is the input minus the centre of four-level hexagon k: (2E,0), (E,S), (-E,S), (-2E,0), (-E,-S), (E,-S) for k = 1 to 6, where S = floor(E·113512/65536).
- R4: Let Rin = floor(E·43691/65536). When the first-stage vector has alpha²+beta² ≤ Rin², hex2_idx is 0 and the outputs equal the first-stage vector.
- R5: Full mode (mode_reduced = 0), outer case: hex2_idx m (1 to 12) is chosen from the first-stage angle. Odd m = 2j+1 covers [60j-20°, 60j+20°). Even m = 2j+2 covers [60j+20°, 60j+40°).
- R6: In full mode the outputs are the first-stage vector minus the centre of m. Odd m = 2j+1 has its centre at (2Rin,0), (Rin,2Q), (-Rin,2Q), (-2Rin,0), (-Rin,-2Q), (Rin,-2Q) for j = 0 to 5. Even m = 2j+2 has its centre at (E,Q), (0,2Q), (-E,Q), (-E,-Q), (0,-2Q), (E,-Q) for j = 0 to 5. Here Q = floor(E·37837/65536).
- R7: Reduced mode (mode_reduced = 1), outer case: hex2_idx j+1 (1 to 6) covers [60j°, 60j+60°). The outputs are the first-stage vector minus the odd-hexagon centre with the same j given in R6.
- R8: In reduced mode, a first-stage vector outside every covered hexagon is still given an outer index by angle and is still translated by R7.
- R9: A vector that lies exactly on a window boundary belongs to the window whose lower limit equals that boundary angle. The half-plane starting at angle φ contains (x,y) when c·y − s·x > 0, or when that term is 0 and c·x + s·y > 0. Here c and s are cos φ and sin φ scaled by 65536 and rounded to the nearest integer.
- R10: While reset is high, and after it until the first result is due, out_valid, hex4_idx, hex2_idx, out_alpha and out_beta are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_alpha | input | IN_W | Reference alpha component, signed |
| in_beta | input | IN_W | Reference beta component, signed |
| e_level | input | E_W | Cell voltage step E, unsigned, sampled with each input |
| mode_reduced | input | 1 | 0 selects twelve outer hexagons, 1 selects six |
| out_valid | output | 1 | Result strobe |
| hex4_idx | output | 3 | Four-level hexagon, 1 to 6 |
| hex2_idx | output | 4 | Two-level hexagon: 0 inner, 1 to 12 outer |
| out_alpha | output | OW | Translated alpha, signed, OW = max(IN_W,E_W)+4 |
| out_beta | output | OW | Translated beta, signed |

## Verification
Every result is due three clock cycles after its input is sampled: one register stage for the four-level choice, one for the two-level choice and one for the final subtraction. The bench drives a new input, or a gap, at each falling edge. It keeps a four-slot ring of expected results, and at each falling edge it compares the outputs against the slot that was driven three falling edges earlier. A slot that was a gap expects out_valid low. This keeps back-to-back samples, gaps and changes of E and mode aligned to the cycle in which each output changes.

// File: rtl/svd_pkg.sv
package svd_pkg;

    localparam int FRAC = 16;

    typedef logic signed [63:0] wide_t;
    typedef logic [2:0]         hex4_t;
    typedef logic [3:0]         hex2_t;

    typedef enum logic {SEL_FULL = 1'b0, SEL_REDUCED = 1'b1} sel_mode_e;

    typedef struct packed {
        logic      valid;
        hex4_t     hex4;
        hex2_t     hex2;
        sel_mode_e mode;
    } tag_t;

    // Scale factors in Q16
    localparam wide_t K_ROOT3      = 64'sd113512;
    localparam wide_t K_TWO_THIRDS = 64'sd43691;
    localparam wide_t K_INV_ROOT3  = 64'sd37837;

    // Unit directions in Q16
    localparam wide_t ONE  = 64'sd65536;
    localparam wide_t HALF = 64'sd32768;
    localparam wide_t C30  = 64'sd56756;
    localparam wide_t C20  = 64'sd61584;
    localparam wide_t S20  = 64'sd22415;
    localparam wide_t C40  = 64'sd50203;
    localparam wide_t S40  = 64'sd42126;
    localparam wide_t C80  = 64'sd11380;
    localparam wide_t S80  = 64'sd64540;

    function automatic wide_t scale_e(input wide_t e, input wide_t k);
        return (e * k) >>> FRAC;
    endfunction

    // True when (x,y) lies in the half-plane [phi, phi+180) of direction (ux,uy)
    function automatic logic in_half(input wide_t ux, input wide_t uy,
                                     input wide_t x, input wide_t y);
        wide_t cr;
        wide_t dt;
        cr = ux * y - uy * x;
        dt = ux * x + uy * y;
        return (cr > 0) || ((cr == 0) && (dt > 0));
    endfunction

    // Three half-planes at 30/90/150 degrees -> 1..6
    function automatic hex4_t decode_hex4(input logic [2:0] h);
        int n;
        n = $countones(h);
        if (h[0])        return hex4_t'(n + 1);
        else if (n == 0) return hex4_t'(1);
        else             return hex4_t'(7 - n);
    endfunction

    // Three half-planes at 0/60/120 degrees -> 1..6
    function automatic hex2_t decode_reduced(input logic [2:0] h);
        int n;
        n = $countones(h);
        if (h[0]) return hex2_t'(n);
        else      return hex2_t'(6 - n);
    endfunction

    // Six half-planes at 20/40/80/100/140/160 degrees -> 1..12
    function automatic hex2_t decode_full(input logic [5:0] h);
        int n;
        n = $countones(h);
        if (h[0])        return hex2_t'(n + 1);
        else if (n == 0) return hex2_t'(1);
        else             return hex2_t'(13 - n);
    endfunction

endpackage

// File: rtl/svd_hex4_stage.sv
module svd_hex4_stage
    import svd_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int E_W  = 16,
    parameter int OW   = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_alpha,
    input  logic signed [IN_W-1:0] in_beta,
    input  logic [E_W-1:0]         e_level,
    input  logic                   mode_reduced,
    output tag_t                   s1_tag,
    output logic signed [OW-1:0]   s1_alpha,
    output logic signed [OW-1:0]   s1_beta,
    output logic [E_W-1:0]         s1_e
);

    wide_t      a, b, e, root3e, cx, cy, dx, dy;
    logic [2:0] side;
    hex4_t      sel;

    always_comb begin
        a      = wide_t'(in_alpha);
        b      = wide_t'(in_beta);
        e      = wide_t'(e_level);
        root3e = scale_e(e, K_ROOT3);
        side[0] = in_half(C30, HALF, a, b);
        side[1] = in_half(64'sd0, ONE, a, b);
        side[2] = in_half(-C30, HALF, a, b);
        sel = decode_hex4(side);
        case (sel)
            3'd1:    begin cx =  2 * e; cy = 64'sd0;  end
            3'd2:    begin cx =  e;     cy =  root3e; end
            3'd3:    begin cx = -e;     cy =  root3e; end
            3'd4:    begin cx = -2 * e; cy = 64'sd0;  end
            3'd5:    begin cx = -e;     cy = -root3e; end
            3'd6:    begin cx =  e;     cy = -root3e; end
            default: begin cx = 64'sd0; cy = 64'sd0;  end
        endcase
        dx = a - cx;
        dy = b - cy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_tag   <= '0;
            s1_alpha <= '0;
            s1_beta  <= '0;
            s1_e     <= '0;
        end else begin
            s1_tag.valid <= in_valid;
            if (in_valid) begin
                s1_tag.hex4 <= sel;
                s1_tag.hex2 <= '0;
                s1_tag.mode <= sel_mode_e'(mode_reduced);
                s1_alpha    <= dx[OW-1:0];
                s1_beta     <= dy[OW-1:0];
                s1_e        <= e_level;
            end
        end
    end

endmodule

// File: rtl/svd_sub_select.sv
module svd_sub_select
    import svd_pkg::*;
#(
    parameter int E_W = 16,
    parameter int OW  = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tag_t                 s1_tag,
    input  logic signed [OW-1:0] s1_alpha,
    input  logic signed [OW-1:0] s1_beta,
    input  logic [E_W-1:0]       s1_e,
    output tag_t                 s2_tag,
    output logic signed [OW-1:0] s2_alpha,
    output logic signed [OW-1:0] s2_beta,
    output logic [E_W-1:0]       s2_e
);

    localparam int NFULL = 6;
    localparam int NRED  = 3;
    localparam wide_t FULL_X [NFULL] = '{C20, C40, C80, -C80, -C40, -C20};
    localparam wide_t FULL_Y [NFULL] = '{S20, S40, S80,  S80,  S40,  S20};
    localparam wide_t RED_X  [NRED]  = '{ONE, HALF, -HALF};
    localparam wide_t RED_Y  [NRED]  = '{64'sd0, C30, C30};

    wide_t            a, b, rad, mag;
    logic             inner;
    logic [NFULL-1:0] fh;
    logic [NRED-1:0]  rh;
    hex2_t            pick;

    always_comb begin
        a     = wide_t'(s1_alpha);
        b     = wide_t'(s1_beta);
        rad   = scale_e(wide_t'(s1_e), K_TWO_THIRDS);
        mag   = a * a + b * b;
        inner = (mag <= rad * rad);
        for (int k = 0; k < NFULL; k++) fh[k] = in_half(FULL_X[k], FULL_Y[k], a, b);
        for (int k = 0; k < NRED; k++)  rh[k] = in_half(RED_X[k], RED_Y[k], a, b);
        if (inner)                          pick = '0;
        else if (s1_tag.mode == SEL_REDUCED) pick = decode_reduced(rh);
        else                                 pick = decode_full(fh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_tag   <= '0;
            s2_alpha <= '0;
            s2_beta  <= '0;
            s2_e     <= '0;
        end else begin
            s2_tag.valid <= s1_tag.valid;
            if (s1_tag.valid) begin
                s2_tag.hex4 <= s1_tag.hex4;
                s2_tag.hex2 <= pick;
                s2_tag.mode <= s1_tag.mode;
                s2_alpha    <= s1_alpha;
                s2_beta     <= s1_beta;
                s2_e        <= s1_e;
            end
        end
    end

endmodule

// File: rtl/svd_sub_translate.sv
module svd_sub_translate
    import svd_pkg::*;
#(
    parameter int E_W = 16,
    parameter int OW  = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tag_t                 s2_tag,
    input  logic signed [OW-1:0] s2_alpha,
    input  logic signed [OW-1:0] s2_beta,
    input  logic [E_W-1:0]       s2_e,
    output logic                 out_valid,
    output hex4_t                hex4_idx,
    output hex2_t                hex2_idx,
    output logic signed [OW-1:0] out_alpha,
    output logic signed [OW-1:0] out_beta
);

    wide_t e, rad, isq, cx, cy, dx, dy;
    hex2_t fidx;

    always_comb begin
        e   = wide_t'(s2_e);
        rad = scale_e(e, K_TWO_THIRDS);
        isq = scale_e(e, K_INV_ROOT3);
        if (s2_tag.mode == SEL_REDUCED && s2_tag.hex2 != '0)
            fidx = hex2_t'(2 * s2_tag.hex2 - 1);
        else
            fidx = s2_tag.hex2;
        case (fidx)
            4'd1:    begin cx =  2 * rad; cy = 64'sd0;   end
            4'd2:    begin cx =  e;       cy =  isq;     end
            4'd3:    begin cx =  rad;     cy =  2 * isq; end
            4'd4:    begin cx = 64'sd0;   cy =  2 * isq; end
            4'd5:    begin cx = -rad;     cy =  2 * isq; end
            4'd6:    begin cx = -e;       cy =  isq;     end
            4'd7:    begin cx = -2 * rad; cy = 64'sd0;   end
            4'd8:    begin cx = -e;       cy = -isq;     end
            4'd9:    begin cx = -rad;     cy = -2 * isq; end
            4'd10:   begin cx = 64'sd0;   cy = -2 * isq; end
            4'd11:   begin cx =  rad;     cy = -2 * isq; end
            4'd12:   begin cx =  e;       cy = -isq;     end
            default: begin cx = 64'sd0;   cy = 64'sd0;   end
        endcase
        dx = wide_t'(s2_alpha) - cx;
        dy = wide_t'(s2_beta) - cy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            hex4_idx  <= '0;
            hex2_idx  <= '0;
            out_alpha <= '0;
            out_beta  <= '0;
        end else begin
            out_valid <= s2_tag.valid;
            if (s2_tag.valid) begin
                hex4_idx  <= s2_tag.hex4;
                hex2_idx  <= s2_tag.hex2;
                out_alpha <= dx[OW-1:0];
                out_beta  <= dy[OW-1:0];
            end
        end
    end

endmodule

// File: rtl/svd_ref_decomposer.sv
module svd_ref_decomposer
    import svd_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int E_W  = 16,
    localparam int OW  = ((IN_W > E_W) ? IN_W : E_W) + 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_alpha,
    input  logic signed [IN_W-1:0] in_beta,
    input  logic [E_W-1:0]         e_level,
    input  logic                   mode_reduced,
    output logic                   out_valid,
    output logic [2:0]             hex4_idx,
    output logic [3:0]             hex2_idx,
    output logic signed [OW-1:0]   out_alpha,
    output logic signed [OW-1:0]   out_beta
);

    tag_t                 s1_tag, s2_tag;
    logic signed [OW-1:0] s1_alpha, s1_beta, s2_alpha, s2_beta;
    logic [E_W-1:0]       s1_e, s2_e;

    svd_hex4_stage #(.IN_W(IN_W), .E_W(E_W), .OW(OW)) u_hex4 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_alpha(in_alpha), .in_beta(in_beta),
        .e_level(e_level), .mode_reduced(mode_reduced),
        .s1_tag(s1_tag), .s1_alpha(s1_alpha), .s1_beta(s1_beta), .s1_e(s1_e)
    );

    svd_sub_select #(.E_W(E_W), .OW(OW)) u_sel (
        .clk(clk), .rst(rst),
        .s1_tag(s1_tag), .s1_alpha(s1_alpha), .s1_beta(s1_beta), .s1_e(s1_e),
        .s2_tag(s2_tag), .s2_alpha(s2_alpha), .s2_beta(s2_beta), .s2_e(s2_e)
    );

    svd_sub_translate #(.E_W(E_W), .OW(OW)) u_xlt (
        .clk(clk), .rst(rst),
        .s2_tag(s2_tag), .s2_alpha(s2_alpha), .s2_beta(s2_beta), .s2_e(s2_e),
        .out_valid(out_valid), .hex4_idx(hex4_idx), .hex2_idx(hex2_idx),
        .out_alpha(out_alpha), .out_beta(out_beta)
    );

endmodule

// File: rtl/svd_ref_checker.sv
module svd_ref_checker
    import svd_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int E_W  = 16,
    localparam int OW  = ((IN_W > E_W) ? IN_W : E_W) + 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [E_W-1:0]       e_level,
    input logic                 mode_reduced,
    input logic                 out_valid,
    input logic [2:0]           hex4_idx,
    input logic [3:0]           hex2_idx,
    input logic signed [OW-1:0] out_alpha,
    input logic signed [OW-1:0] out_beta
);

    function automatic wide_t sq_inner(input logic [E_W-1:0] e);
        wide_t r;
        r = scale_e(wide_t'(e), K_TWO_THIRDS);
        return r * r;
    endfunction

    // R1
    lat_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R1
    lat_back_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_alpha) && $stable(out_beta) && $stable(hex2_idx)));

    // R2
    hex4_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (hex4_idx >= 3'd1 && hex4_idx <= 3'd6));

    // R5
    hex2_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (hex2_idx <= 4'd12));

    // R7
    reduced_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode_reduced, 3)) |-> (hex2_idx <= 4'd6));

    // R4
    inner_mag_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && hex2_idx == 4'd0) |->
        (wide_t'(out_alpha) * wide_t'(out_alpha) + wide_t'(out_beta) * wide_t'(out_beta)
            <= sq_inner($past(e_level, 3))));

endmodule

bind svd_ref_decomposer svd_ref_checker #(.IN_W(IN_W), .E_W(E_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .e_level(e_level),
    .mode_reduced(mode_reduced), .out_valid(out_valid),
    .hex4_idx(hex4_idx), .hex2_idx(hex2_idx),
    .out_alpha(out_alpha), .out_beta(out_beta)
);

// File: tb/sim_svd_ref_decomposer.sv
module sim_svd_ref_decomposer;

    localparam int IN_W = 16;
    localparam int E_W  = 16;
    localparam int OW   = 20;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                   rst;
    logic                   in_valid;
    logic signed [IN_W-1:0] in_alpha, in_beta;
    logic [E_W-1:0]         e_level;
    logic                   mode_reduced;
    logic                   out_valid;
    logic [2:0]             hex4_idx;
    logic [3:0]             hex2_idx;
    logic signed [OW-1:0]   out_alpha, out_beta;

    svd_ref_decomposer #(.IN_W(IN_W), .E_W(E_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_alpha(in_alpha), .in_beta(in_beta), .e_level(e_level),
        .mode_reduced(mode_reduced), .out_valid(out_valid),
        .hex4_idx(hex4_idx), .hex2_idx(hex2_idx),
        .out_alpha(out_alpha), .out_beta(out_beta)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    bit     pv  [4];
    int     ph4 [4];
    int     ph2 [4];
    longint pa  [4];
    longint pb  [4];
    string  ptg [4];

    function automatic longint qv(input real x);
        return longint'($floor(x * 65536.0 + 0.5));
    endfunction

    // R9: half-plane [deg, deg+180)
    function automatic bit hp(input int deg, input longint x, input longint y);
        real    rad;
        longint ux, uy, cr, dt;
        rad = deg * 3.14159265358979 / 180.0;
        ux  = qv($cos(rad));
        uy  = qv($sin(rad));
        cr  = ux * y - uy * x;
        dt  = ux * x + uy * y;
        return (cr > 0) || (cr == 0 && dt > 0);
    endfunction

    function automatic bit inwin(input int lo, input int hi, input longint x, input longint y);
        return hp(lo, x, y) && !hp(hi, x, y);
    endfunction

    task automatic model(input longint a, input longint b, input longint e, input bit red,
                         output int h4, output int h2, output longint oa, output longint ob);
        longint s, r, q, c1x, c1y, vx, vy, cx, cy;
        int f, j;
        s = (e * 113512) >>> 16;
        r = (e * 43691) >>> 16;
        q = (e * 37837) >>> 16;
        h4 = 1;
        if (!(a == 0 && b == 0))
            for (int k = 0; k < 6; k++)
                if (inwin(60 * k - 30, 60 * k + 30, a, b)) h4 = k + 1;
        case (h4)
            1: begin c1x =  2 * e; c1y = 0;  end
            2: begin c1x =  e;     c1y =  s; end
            3: begin c1x = -e;     c1y =  s; end
            4: begin c1x = -2 * e; c1y = 0;  end
            5: begin c1x = -e;     c1y = -s; end
            default: begin c1x = e; c1y = -s; end
        endcase
        vx = a - c1x;
        vy = b - c1y;
        h2 = 0;
        f  = 0;
        if (vx * vx + vy * vy > r * r) begin
            if (red) begin
                for (int k = 0; k < 6; k++)
                    if (inwin(60 * k, 60 * k + 60, vx, vy)) h2 = k + 1;
                f = 2 * h2 - 1;
            end else begin
                for (int m = 1; m <= 12; m++) begin
                    int base = 60 * ((m - 1) / 2);
                    if (m % 2 == 1) begin
                        if (inwin(base - 20, base + 20, vx, vy)) h2 = m;
                    end else begin
                        if (inwin(base + 20, base + 40, vx, vy)) h2 = m;
                    end
                end
                f = h2;
            end
        end
        cx = 0;
        cy = 0;
        if (f != 0 && f % 2 == 1) begin
            j = (f - 1) / 2;
            case (j)
                0: begin cx =  2 * r; cy = 0;      end
                1: begin cx =  r;     cy =  2 * q; end
                2: begin cx = -r;     cy =  2 * q; end
                3: begin cx = -2 * r; cy = 0;      end
                4: begin cx = -r;     cy = -2 * q; end
                default: begin cx = r; cy = -2 * q; end
            endcase
        end else if (f != 0) begin
            j = (f - 2) / 2;
            case (j)
                0: begin cx =  e; cy =  q;     end
                1: begin cx =  0; cy =  2 * q; end
                2: begin cx = -e; cy =  q;     end
                3: begin cx = -e; cy = -q;     end
                4: begin cx =  0; cy = -2 * q; end
                default: begin cx = e; cy = -q; end
            endcase
        end
        oa = vx - cx;
        ob = vy - cy;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One cycle: check the slot due now, then drive a new input or a gap
    task automatic step(input bit v, input longint a, input longint b, input bit red, input string tag);
        int slot, h4, h2;
        longint oa, ob;
        @(negedge clk);
        slot = (cyc + 1) % 4;
        n_cmp++;
        if (pv[slot]) begin
            if (!(out_valid === 1'b1 && int'(hex4_idx) == ph4[slot] && int'(hex2_idx) == ph2[slot]
                  && longint'(out_alpha) == pa[slot] && longint'(out_beta) == pb[slot])) begin
                n_bad++;
                $display("FAIL %s: got valid=%0b hex4=%0d hex2=%0d a=%0d b=%0d, expected valid=1 hex4=%0d hex2=%0d a=%0d b=%0d",
                         ptg[slot], out_valid, hex4_idx, hex2_idx, out_alpha, out_beta,
                         ph4[slot], ph2[slot], pa[slot], pb[slot]);
            end
        end else if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got out_valid=%0b in idle slot, expected 0", out_valid);
        end
        in_valid     = v;
        in_alpha     = IN_W'(a);
        in_beta      = IN_W'(b);
        mode_reduced = red;
        slot = cyc % 4;
        pv[slot]  = v;
        ptg[slot] = tag;
        if (v) begin
            model(a, b, longint'(e_level), red, h4, h2, oa, ob);
            ph4[slot] = h4;
            ph2[slot] = h2;
            pa[slot]  = oa;
            pb[slot]  = ob;
        end
        cyc++;
    endtask

    task automatic flush();
        for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 1'b0, "R1");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of run");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) pv[k] = 1'b0;
        rst = 1'b1;
        in_valid = 1'b0;
        in_alpha = '0;
        in_beta = '0;
        e_level = 16'd3000;
        mode_reduced = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        n_cmp++;
        if (out_valid !== 1'b0 || hex4_idx !== 3'd0 || hex2_idx !== 4'd0
            || out_alpha !== '0 || out_beta !== '0) begin
            n_bad++;
            $display("FAIL R10: got valid=%0b hex4=%0d hex2=%0d a=%0d b=%0d, expected all 0",
                     out_valid, hex4_idx, hex2_idx, out_alpha, out_beta);
        end
        rst = 1'b0;
        flush();

        // Directed corners with E = 3000
        step(1'b1, 0, 0, 1'b0, "R2");            // zero vector -> hexagon 1
        step(1'b1, 6000, 0, 1'b0, "R3");         // lands on first-stage centre
        step(1'b1, 8000, 0, 1'b0, "R4");         // magnitude equals inner radius
        step(1'b1, 8001, 0, 1'b0, "R4");         // one step past inner radius
        step(1'b1, 0, 500, 1'b0, "R9");          // on the 90 degree line
        step(1'b1, 6000, 2500, 1'b0, "R9");      // first-stage at exactly 90 degrees
        step(1'b1, 6000, 2500, 1'b1, "R9");
        step(1'b1, 8500, 0, 1'b1, "R9");         // first-stage at exactly 0 degrees
        step(1'b1, 3950, 0, 1'b1, "R9");         // first-stage at exactly 180 degrees
        step(1'b1, 3950, 0, 1'b0, "R9");
        flush();

        // Angle sweeps over two E values, both modes, several radii
        for (int ei = 0; ei < 2; ei++) begin
            e_level = (ei == 0) ? 16'd3000 : 16'd1234;
            for (int md = 0; md < 2; md++) begin
                for (int rk = 0; rk < 6; rk++) begin
                    real rad;
                    string tg;
                    rad = real'(e_level) * ((rk == 0) ? 0.07 : 0.65 * rk);
                    if (md == 1) tg = (rk >= 5) ? "R8" : "R7";
                    else         tg = (rk % 2 == 1) ? "R6" : "R5";
                    for (int an = 0; an < 120; an++) begin
                        real th;
                        th = (3.0 * an + 1.0) * 3.14159265358979 / 180.0;
                        step(1'b1, longint'($floor(rad * $cos(th) + 0.5)),
                             longint'($floor(rad * $sin(th) + 0.5)), md[0], tg);
                        if (an % 7 == 6) step(1'b0, 0, 0, 1'b0, "R1");
                    end
                end
            end
            flush();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule